// File: doc/BRIEF.md
# Configurable Product-Term AND Plane

This block is the AND plane of one programmable logic block. Every input signal is offered as two lines, its true value and its complement. Each product-term output is the AND of whichever of those lines its stored connection mask selects. The outputs follow the inputs combinationally, so the plane sits between the input routing and the downstream logic allocator without adding a pipeline stage.

There are 83 terms. Terms 0 to 79 are logic terms. They form 16 clusters of five consecutive terms, one cluster per macrocell. The last three terms are shared control terms for the block: a clock term, an initialization term and an output-enable term. The clock and initialization terms can each be inverted by a configuration input before they leave the block. Connection masks are loaded one term at a time through a synchronous write port, and a reset empties every mask.

Top module: `pterm_and_plane`

## Requirements
- R1: Mask bit 2i connects the true line of input i and mask bit 2i+1 connects its complement line, for i from 0 to 35.
- R2: Each term is the AND of the lines its mask connects, and it follows an input change in the same cycle with no clock edge in between.
- R3: A term whose mask is all zero outputs 1 for every input value.
- R4: A term whose mask connects both the true and the complement line of the same input outputs 0 for every input value.
- R5: Logic term k (0 to 79) appears on `logic_terms[k]`. Cluster c occupies bits 5c to 5c+4, and a change to one term's mask affects no other output bit.
- R6: Term 80 drives `shared_clk`, inverted when `inv_clk` is 1.
- R7: Term 81 drives `shared_init`, inverted when `inv_init` is 1.
- R8: Term 82 drives `shared_oe` and is never inverted, whatever the inversion inputs are.
- R9: When `wr_en` is 1 at a rising clock edge, `wr_mask` replaces the mask of term `wr_idx`. Outputs show the old mask before that edge and the new mask after it.
- R10: A write whose `wr_idx` is 83 or more changes no mask.
- R11: An active-low reset clears every mask, so that every term outputs 1 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the mask write port |
| rst_n | input | 1 | Asynchronous active-low reset, clears all masks |
| in_vec | input | 36 | Input signals to the plane |
| wr_en | input | 1 | Write strobe for one term's mask |
| wr_idx | input | 7 | Index of the term to write (0 to 82) |
| wr_mask | input | 72 | Connection mask, two bits per input |
| inv_clk | input | 1 | Inverts the shared clock term |
| inv_init | input | 1 | Inverts the shared initialization term |
| logic_terms | output | 80 | Logic terms 0 to 79, five per cluster |
| shared_clk | output | 1 | Shared clock term (term 80) |
| shared_init | output | 1 | Shared initialization term (term 81) |
| shared_oe | output | 1 | Shared output-enable term (term 82) |

## Verification
Single-line masks on the true line and then on the complement line, each tried with the input at 0 and at 1, tell the two line polarities apart and expose a swapped interleave. Masks that span all 36 inputs, driven with one input bit flipped, show that every connected line takes part in the AND and not only the low ones. A conflicting pair written into one term, with all other terms left empty, shows that no other output bit moves and that cluster positions are right. Random sparse masks across all 83 terms are compared against a reference AND. Their input vectors are drawn near a vector that satisfies the masks, so that both the 1 and the 0 results occur often.

// File: rtl/pterm_and_plane_pkg.sv
package pterm_and_plane_pkg;
   // Position of each shared control term after the logic terms
   typedef enum int {
      SH_CLK  = 0,
      SH_INIT = 1,
      SH_OE   = 2
   } shared_slot_e;

   localparam int unsigned SHARED_COUNT = 3;

   // Mask bit index of a line: true line even, complement line odd
   function automatic int unsigned line_pos(int unsigned inp, bit compl);
      return 2 * inp + (compl ? 1 : 0);
   endfunction
endpackage

// File: rtl/pterm_line_gen.sv
module pterm_line_gen #(
   parameter int unsigned N_IN = 36,
   localparam int unsigned N_LINE = 2 * N_IN
) (
   input  logic [N_IN-1:0]   in_vec,
   output logic [N_LINE-1:0] lines
);
   import pterm_and_plane_pkg::*;

   for (genvar i = 0; i < N_IN; i++) begin : g_pair
      assign lines[line_pos(i, 1'b0)] = in_vec[i];
      assign lines[line_pos(i, 1'b1)] = ~in_vec[i];
   end
endmodule

// File: rtl/pterm_mask_store.sv
module pterm_mask_store #(
   parameter int unsigned N_TERM = 83,
   parameter int unsigned N_LINE = 72,
   parameter int unsigned AW     = 7
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       wr_en,
   input  logic [AW-1:0]              wr_idx,
   input  logic [N_LINE-1:0]          wr_mask,
   output logic [N_TERM*N_LINE-1:0]   masks_flat
);
   for (genvar k = 0; k < N_TERM; k++) begin : g_entry
      logic [N_LINE-1:0] mask_q;
      logic              hit;

      assign hit = wr_en && (wr_idx == AW'(k));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mask_q <= '0;
         else if (hit)
            mask_q <= wr_mask;
      end

      assign masks_flat[k*N_LINE +: N_LINE] = mask_q;
   end
endmodule

// File: rtl/pterm_term_and.sv
module pterm_term_and #(
   parameter int unsigned N_LINE = 72
) (
   input  logic [N_LINE-1:0] lines,
   input  logic [N_LINE-1:0] mask,
   output logic              term
);
   // An unconnected line counts as 1, so an empty mask yields 1
   assign term = &(lines | ~mask);
endmodule

// File: rtl/pterm_and_plane.sv
module pterm_and_plane #(
   parameter int unsigned N_IN      = 36,
   parameter int unsigned N_CLUST   = 16,
   parameter int unsigned CLUST_SZ  = 5,
   parameter int unsigned N_SHARED  = 3,
   localparam int unsigned N_LINE   = 2 * N_IN,
   localparam int unsigned N_LOGIC  = N_CLUST * CLUST_SZ,
   localparam int unsigned N_TERM   = N_LOGIC + N_SHARED,
   localparam int unsigned AW       = $clog2(N_TERM)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [N_IN-1:0]    in_vec,
   input  logic               wr_en,
   input  logic [AW-1:0]      wr_idx,
   input  logic [N_LINE-1:0]  wr_mask,
   input  logic               inv_clk,
   input  logic               inv_init,
   output logic [N_LOGIC-1:0] logic_terms,
   output logic               shared_clk,
   output logic               shared_init,
   output logic               shared_oe
);
   import pterm_and_plane_pkg::*;

   // Elaboration-time parameter checks
   if (N_IN < 1) begin : g_bad_in
      $error("pterm_and_plane: N_IN must be at least 1");
   end
   if (CLUST_SZ < 1 || N_CLUST < 1) begin : g_bad_clust
      $error("pterm_and_plane: cluster count and size must be nonzero");
   end
   if (N_SHARED != SHARED_COUNT) begin : g_bad_shared
      $error("pterm_and_plane: N_SHARED must equal SHARED_COUNT");
   end

   logic [N_LINE-1:0]        lines;
   logic [N_TERM*N_LINE-1:0] masks_flat;
   logic [N_TERM-1:0]        raw_terms;
   logic [N_SHARED-1:0]      shared_out;

   pterm_line_gen #(.N_IN(N_IN)) u_lines (
      .in_vec (in_vec),
      .lines  (lines)
   );

   pterm_mask_store #(.N_TERM(N_TERM), .N_LINE(N_LINE), .AW(AW)) u_store (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (wr_en),
      .wr_idx     (wr_idx),
      .wr_mask    (wr_mask),
      .masks_flat (masks_flat)
   );

   for (genvar k = 0; k < N_TERM; k++) begin : g_term
      pterm_term_and #(.N_LINE(N_LINE)) u_and (
         .lines (lines),
         .mask  (masks_flat[k*N_LINE +: N_LINE]),
         .term  (raw_terms[k])
      );
   end

   assign logic_terms = raw_terms[N_LOGIC-1:0];

   for (genvar s = 0; s < N_SHARED; s++) begin : g_shared
      if (s == int'(SH_OE)) begin : g_plain
         assign shared_out[s] = raw_terms[N_LOGIC+s];
      end else if (s == int'(SH_CLK)) begin : g_inv_clk
         assign shared_out[s] = raw_terms[N_LOGIC+s] ^ inv_clk;
      end else begin : g_inv_init
         assign shared_out[s] = raw_terms[N_LOGIC+s] ^ inv_init;
      end
   end

   assign shared_clk  = shared_out[SH_CLK];
   assign shared_init = shared_out[SH_INIT];
   assign shared_oe   = shared_out[SH_OE];
endmodule

// File: rtl/pterm_and_plane_chk.sv
module pterm_and_plane_chk #(
   parameter int unsigned N_LINE  = 72,
   parameter int unsigned N_LOGIC = 80,
   parameter int unsigned N_TERM  = 83,
   parameter int unsigned AW      = 7
) (
   input logic                     clk,
   input logic                     rst_n,
   input logic                     wr_en,
   input logic [AW-1:0]            wr_idx,
   input logic [N_LINE-1:0]        wr_mask,
   input logic                     inv_clk,
   input logic                     inv_init,
   input logic [N_TERM*N_LINE-1:0] masks_flat,
   input logic [N_LOGIC-1:0]       logic_terms,
   input logic                     shared_clk,
   input logic                     shared_init,
   input logic                     shared_oe
);
   // R9: a write in range is held by the addressed term after the edge
   a_r9_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) < N_TERM)) |=>
         (masks_flat[int'($past(wr_idx))*N_LINE +: N_LINE] == $past(wr_mask)));

   // R10: a write out of range leaves all masks as they were
   a_r10_idx_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && (int'(wr_idx) >= N_TERM)) |=> $stable(masks_flat));

   // R4: both lines of input 0 on term 0 force it low
   a_r4_conflict_low: assert property (@(posedge clk) disable iff (!rst_n)
      (masks_flat[1:0] == 2'b11) |-> !logic_terms[0]);

   // R6: empty clock term shows only the inversion setting
   a_r6_clk_inversion: assert property (@(posedge clk) disable iff (!rst_n)
      (masks_flat[N_LOGIC*N_LINE +: N_LINE] == '0) |-> (shared_clk == !inv_clk));

   // R7: empty initialization term shows only the inversion setting
   a_r7_init_inversion: assert property (@(posedge clk) disable iff (!rst_n)
      (masks_flat[(N_LOGIC+1)*N_LINE +: N_LINE] == '0) |-> (shared_init == !inv_init));

   // R8: empty output-enable term is 1 whatever the inversion inputs
   a_r8_oe_plain: assert property (@(posedge clk) disable iff (!rst_n)
      (masks_flat[(N_LOGIC+2)*N_LINE +: N_LINE] == '0) |-> shared_oe);

   // R11: on the first edge after reset every logic term reads 1
   a_r11_reset_clear: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (&logic_terms && shared_oe));
endmodule

bind pterm_and_plane pterm_and_plane_chk #(
   .N_LINE(N_LINE), .N_LOGIC(N_LOGIC), .N_TERM(N_TERM), .AW(AW)
) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .wr_en       (wr_en),
   .wr_idx      (wr_idx),
   .wr_mask     (wr_mask),
   .inv_clk     (inv_clk),
   .inv_init    (inv_init),
   .masks_flat  (masks_flat),
   .logic_terms (logic_terms),
   .shared_clk  (shared_clk),
   .shared_init (shared_init),
   .shared_oe   (shared_oe)
);

// File: tb/test_pterm_and_plane.sv
module test_pterm_and_plane;
   localparam int NI = 36;
   localparam int NL = 72;
   localparam int NG = 80;
   localparam int NT = 83;

   typedef struct packed {
      logic [6:0]    idx;
      logic [NI-1:0] tsel;
      logic [NI-1:0] csel;
      logic [NI-1:0] inp;
      logic          exp;
   } vec_t;

   localparam vec_t TABLE [10] = '{
      '{7'd0,  36'h000000001, 36'h000000000, 36'h000000001, 1'b1},
      '{7'd0,  36'h000000001, 36'h000000000, 36'h000000000, 1'b0},
      '{7'd4,  36'h000000000, 36'h000000002, 36'h000000000, 1'b1},
      '{7'd4,  36'h000000000, 36'h000000002, 36'h000000002, 1'b0},
      '{7'd79, 36'hF0000000F, 36'h0F0000000, 36'hF0000000F, 1'b1},
      '{7'd79, 36'hF0000000F, 36'h0F0000000, 36'hF1000000F, 1'b0},
      '{7'd82, 36'h800000000, 36'h000000000, 36'h800000000, 1'b1},
      '{7'd40, 36'hFFFFFFFFF, 36'h000000000, 36'hFFFFFFFFF, 1'b1},
      '{7'd40, 36'hFFFFFFFFF, 36'h000000000, 36'hFFFFFFFFE, 1'b0},
      '{7'd55, 36'h000000000, 36'hFFFFFFFFF, 36'h000000000, 1'b1}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NI-1:0] in_vec = '0;
   logic          wr_en = 1'b0;
   logic [6:0]    wr_idx = '0;
   logic [NL-1:0] wr_mask = '0;
   logic          inv_clk = 1'b0;
   logic          inv_init = 1'b0;
   logic [NG-1:0] logic_terms;
   logic          shared_clk, shared_init, shared_oe;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 1'b0;
   logic [NL-1:0] model [NT];

   always #5 clk = ~clk;

   pterm_and_plane i_pterm_and_plane (
      .clk(clk), .rst_n(rst_n), .in_vec(in_vec), .wr_en(wr_en),
      .wr_idx(wr_idx), .wr_mask(wr_mask), .inv_clk(inv_clk),
      .inv_init(inv_init), .logic_terms(logic_terms),
      .shared_clk(shared_clk), .shared_init(shared_init), .shared_oe(shared_oe)
   );

   task automatic check(input bit ok, input string req,
                        input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic finish_up();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   // R1 interleave: bit 2i true line, bit 2i+1 complement line
   function automatic logic [NL-1:0] mk_mask(logic [NI-1:0] t, logic [NI-1:0] c);
      logic [NL-1:0] m;
      for (int i = 0; i < NI; i++) begin
         m[2*i]   = t[i];
         m[2*i+1] = c[i];
      end
      return m;
   endfunction

   function automatic logic ref_term(logic [NL-1:0] m, logic [NI-1:0] x);
      logic r = 1'b1;
      for (int i = 0; i < NI; i++) begin
         if (m[2*i] && !x[i]) r = 1'b0;
         if (m[2*i+1] && x[i]) r = 1'b0;
      end
      return r;
   endfunction

   function automatic logic port_term(int k);
      if (k < NG) return logic_terms[k];
      if (k == 80) return shared_clk;
      if (k == 81) return shared_init;
      return shared_oe;
   endfunction

   task automatic do_write(input int idx, input logic [NL-1:0] m);
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 7'(idx); wr_mask = m;
      @(negedge clk);
      wr_en = 1'b0;
      if (idx < NT) model[idx] = m;
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      for (int k = 0; k < NT; k++) model[k] = '0;
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      finish_up();
   end

   initial begin
      logic [95:0] r1, r2;
      logic [NI-1:0] base;
      logic [NG-1:0] exp_logic;
      logic [2:0] exp_sh;

      do_reset();
      // R11: all terms 1 after reset
      in_vec = 36'h5A5A5A5A5; #1;
      check(&logic_terms && shared_clk && shared_init && shared_oe, "R11 reset",
            {shared_clk, shared_init, shared_oe, logic_terms}, {83{1'b1}});
      // R3: empty masks stay 1 under other inputs
      in_vec = '0; #1;
      check(&logic_terms, "R3 empty zero-in", logic_terms, {NG{1'b1}});
      in_vec = '1; #1;
      check(&logic_terms, "R3 empty ones-in", logic_terms, {NG{1'b1}});

      // R10: out-of-range writes of a conflicting mask change nothing
      do_write(83, '1);
      do_write(127, '1);
      #1;
      check(&logic_terms && shared_clk && shared_init && shared_oe, "R10 out of range",
            {shared_clk, shared_init, shared_oe, logic_terms}, {83{1'b1}});

      // R5 and R4: conflict on term 7 (cluster 1 slot 2) moves only bit 7
      do_write(7, mk_mask(36'h000000020, 36'h000000020));
      in_vec = 36'h000000020; #1;
      check(logic_terms == ~(80'd1 << 7), "R5 cluster position", logic_terms, ~(80'd1 << 7));
      in_vec = 36'h000000000; #1;
      check(logic_terms[7] == 1'b0, "R4 conflict", logic_terms[7], 1'b0);
      check(shared_clk && shared_init && shared_oe, "R5 shared untouched",
            {shared_clk, shared_init, shared_oe}, 3'b111);
      do_write(7, '0);

      // R6, R7, R8: inversion on empty shared terms
      inv_clk = 1'b1; #1;
      check(shared_clk == 1'b0 && shared_init == 1'b1, "R6 clk inverted",
            {shared_clk, shared_init}, 2'b01);
      inv_init = 1'b1; #1;
      check(shared_init == 1'b0, "R7 init inverted", shared_init, 1'b0);
      check(shared_oe == 1'b1, "R8 oe not inverted", shared_oe, 1'b1);
      do_write(80, mk_mask(36'h1, 36'h0));
      in_vec = 36'h0; #1;
      check(shared_clk == 1'b1, "R6 inverted low term", shared_clk, 1'b1);
      inv_clk = 1'b0; inv_init = 1'b0; #1;
      check(shared_clk == 1'b0, "R6 plain low term", shared_clk, 1'b0);

      // R9: old mask before the edge, new mask after it
      in_vec = '0;
      @(negedge clk);
      wr_en = 1'b1; wr_idx = 7'd10; wr_mask = mk_mask(36'h1, 36'h1);
      #1;
      check(logic_terms[10] == 1'b1, "R9 before edge", logic_terms[10], 1'b1);
      @(posedge clk); #1;
      check(logic_terms[10] == 1'b0, "R9 after edge", logic_terms[10], 1'b0);
      @(negedge clk); wr_en = 1'b0;
      model[10] = mk_mask(36'h1, 36'h1);

      // R1: true line of input 1 at bit 2, complement at bit 3
      do_write(12, 72'h4);
      in_vec = 36'h2; #1;
      check(logic_terms[12] == 1'b1, "R1 true line hi", logic_terms[12], 1'b1);
      in_vec = 36'h0; #1;
      check(logic_terms[12] == 1'b0, "R1 true line lo", logic_terms[12], 1'b0);
      do_write(12, 72'h8);
      #1;
      check(logic_terms[12] == 1'b1, "R1 compl line lo", logic_terms[12], 1'b1);
      in_vec = 36'h2; #1;
      check(logic_terms[12] == 1'b0, "R1 compl line hi", logic_terms[12], 1'b0);

      // R2: table of single-term patterns
      foreach (TABLE[e]) begin
         do_write(int'(TABLE[e].idx), mk_mask(TABLE[e].tsel, TABLE[e].csel));
         in_vec = TABLE[e].inp; #1;
         check(port_term(int'(TABLE[e].idx)) == TABLE[e].exp, "R2 table",
               port_term(int'(TABLE[e].idx)), TABLE[e].exp);
      end

      // R2: random sparse masks against a reference AND
      for (int round = 0; round < 20; round++) begin
         r1 = {$urandom, $urandom, $urandom};
         base = r1[NI-1:0];
         for (int k = 0; k < NT; k++) begin
            r1 = {$urandom, $urandom, $urandom};
            r2 = {$urandom, $urandom, $urandom};
            do_write(k, r1[NL-1:0] & r2[NL-1:0] & mk_mask(base, ~base)
                        ^ ((k % 3 == 0) ? (72'd1 << ($urandom % NL)) : 72'd0));
         end
         for (int v = 0; v < 3; v++) begin
            in_vec = (v == 0) ? base : base ^ (36'd1 << ($urandom % NI));
            #1;
            for (int k = 0; k < NG; k++) exp_logic[k] = ref_term(model[k], in_vec);
            for (int s = 0; s < 3; s++) exp_sh[s] = ref_term(model[NG+s], in_vec);
            check(logic_terms == exp_logic, "R2 random logic", logic_terms, exp_logic);
            check({shared_oe, shared_init, shared_clk} == exp_sh, "R2 random shared",
                  {shared_oe, shared_init, shared_clk}, exp_sh);
         end
      end

      // R11: reset after writes empties every mask
      do_reset();
      in_vec = 36'h0; #1;
      check(&logic_terms && shared_clk && shared_init && shared_oe, "R11 reset after writes",
            {shared_clk, shared_init, shared_oe, logic_terms}, {83{1'b1}});

      finish_up();
   end
endmodule